// File: doc/BRIEF.md
# Sticky Fault Status and Response Selector

This block holds the status flags that decide how a sensor device answers its acceleration data requests. The flags are: start-up initialisation still running, a reset has occurred, a writable-register CRC fault, an OTP CRC fault, a self-test fault, and one over-range flag per axis. Each class has its own clearing rule. Some clear when the status register is read, one clears when initialisation completes, one clears only on reset, and one never clears by any operation. An internal-error summary bit is the OR of the three fault causes.

For each data request the block returns a response one cycle later. The response is one of three kinds: internal error, self-test error, or valid data with a 2-bit status field. The same registered result gates the pulse that updates the arming function. A separate level enables the pulse-code output. Over-range status stays reported for one extra request on an axis after the condition clears. The data path and the arming algorithm sit outside this block.

Top module: `fault_resp_sel`

## Requirements
- R1: A synchronous active-low reset sets the init-busy and reset-seen flags, clears all other flags and drives the pulse-code enable low.
- R2: Init-busy clears on the cycle after `init_done_i` is high. Reset-seen clears after a status read. The pulse-code enable is high only when both of these flags are clear.
- R3: While init-busy or reset-seen is set, every request returns kind 2'b01 (internal error) with no arming pulse.
- R4: Either CRC fault sets the internal-error bit. While a CRC flag is set, requests return kind 2'b01 with no arming pulse, and the pulse-code enable is not affected.
- R5: If a writable-register CRC fault is raised while `lock_i` is low, a status read clears it. If it is raised while `lock_i` is high, a status read leaves it set and only reset clears it.
- R6: An OTP CRC fault flag is never cleared by a status read.
- R7: A self-test fault makes requests return kind 2'b10 with no arming pulse. Its flag holds until a status read. A read while the fault is still present leaves the flag set.
- R8: While an axis is over range, requests on that axis return kind 2'b00 with status 2'b10 and an arming pulse. The other axes keep status 2'b00.
- R9: After an axis's over-range ends, the next request on that axis still reports status 2'b10 and later requests report 2'b00. The axis's over-range flag stays set until a status read.
- R10: When several conditions are active, the response priority is init/reset, then CRC, then self-test, then over-range.
- R11: `stat_o` shows the flags as they are before a read in the same cycle clears them. Bit 0 is init-busy, bit 1 reset-seen, bit 2 internal error, bit 3 writable CRC, bit 4 OTP CRC, bit 5 self-test, and bit 6+k is the over-range flag of axis k.
- R12: Each request produces exactly one `rsp_vld_o` pulse on the next cycle. A valid-data response (kind 2'b00) always carries an arming pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done_i | input | 1 | Initialisation complete |
| lock_i | input | 1 | Register lock bit |
| wcrc_fault_i | input | 1 | Writable-register CRC fault pulse |
| otp_fault_i | input | 1 | OTP CRC fault pulse |
| st_fault_i | input | 1 | Self-test failure level |
| ovr_i | input | NAXIS | Per-axis offset over-range level |
| stat_rd_i | input | 1 | Status register read strobe |
| req_i | input | 1 | Data request strobe |
| req_axis_i | input | AXW | Axis of the request |
| stat_o | output | 6+NAXIS | Status flag view |
| rsp_vld_o | output | 1 | Response valid |
| rsp_kind_o | output | 2 | 00 valid, 01 internal error, 10 self-test error |
| rsp_stat_o | output | 2 | Status field of a valid response |
| arm_upd_o | output | 1 | Arming update pulse |
| pcm_en_o | output | 1 | Pulse-code output enable |

## Verification
Requests are issued after reset, during initialisation, during CRC faults raised with and without the lock bit, during a self-test fault that is held and then removed, and during and after an over-range on one axis. Requests on the neighbouring axis show that over-range is tracked per axis. Faults are stacked in pairs (self-test with over-range, CRC with self-test, OTP with init) so the priority order is exposed. Status reads are checked in the read cycle and after it, which separates clear-on-read, locked, permanent and still-present behaviour.

// File: rtl/fault_resp_pkg.sv
// Shared encodings for the fault status and response selector.
package fault_resp_pkg;
    typedef enum logic [1:0] {
        RSP_OK  = 2'b00,
        RSP_INT = 2'b01,
        RSP_ST  = 2'b10
    } rsp_kind_t;

    localparam logic [1:0] ST_NORM = 2'b00;
    localparam logic [1:0] ST_OVR  = 2'b10;

    // Bit positions inside the status view
    localparam int B_INIT = 0;
    localparam int B_RST  = 1;
    localparam int B_IDE  = 2;
    localparam int B_WCRC = 3;
    localparam int B_OTP  = 4;
    localparam int B_ST   = 5;
    localparam int B_OVR0 = 6;
endpackage

// File: rtl/frs_flag_bank.sv
// Device-wide sticky flags and their clearing rules.
// Assumes fault inputs are synchronous to clk. The lock state is sampled
// when a writable CRC fault is raised.
module frs_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done_i,
    input  logic lock_i,
    input  logic wcrc_fault_i,
    input  logic otp_fault_i,
    input  logic st_fault_i,
    input  logic stat_rd_i,
    output logic init_busy_o,
    output logic rst_seen_o,
    output logic wcrc_o,
    output logic otp_o,
    output logic st_err_o
);
    logic wcrc_lk;

    // Update every flag according to its own set and clear rule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_busy_o <= 1'b1;
            rst_seen_o  <= 1'b1;
            wcrc_o      <= 1'b0;
            wcrc_lk     <= 1'b0;
            otp_o       <= 1'b0;
            st_err_o    <= 1'b0;
        end else begin
            if (init_done_i) init_busy_o <= 1'b0;
            if (stat_rd_i)   rst_seen_o  <= 1'b0;
            if (wcrc_fault_i) begin
                wcrc_o  <= 1'b1;
                wcrc_lk <= wcrc_lk | lock_i;
            end else if (stat_rd_i && !wcrc_lk) begin
                wcrc_o <= 1'b0;
            end
            if (otp_fault_i) otp_o <= 1'b1;
            st_err_o <= st_fault_i | (st_err_o & ~stat_rd_i);
        end
    end

    // R2
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_i |=> !init_busy_o);
    // R5
    locked_wcrc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wcrc_o && wcrc_lk) |=> wcrc_o);
    // R6
    otp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_o |=> otp_o);
    // R7
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && st_fault_i) |=> st_err_o);
endmodule

// File: rtl/frs_axis_ovr.sv
// Over-range tracking for one axis: a sticky flag that clears on read,
// and a report bit that stays set for one request after the condition ends.
module frs_axis_ovr (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_i,
    input  logic stat_rd_i,
    input  logic req_hit_i,
    output logic flag_o,
    output logic rpt_o
);
    logic tail;

    // Sticky flag for the status view, re-armed while the condition holds
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= ovr_i | (flag_o & ~stat_rd_i);
    end

    // Tail bit: remembers over-range until a request on this axis consumes it
    always_ff @(posedge clk) begin
        if (!rst_n)         tail <= 1'b0;
        else if (ovr_i)     tail <= 1'b1;
        else if (req_hit_i) tail <= 1'b0;
    end

    assign rpt_o = ovr_i | tail;

    // R9
    tail_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit_i && !ovr_i) |=> (!rpt_o || ovr_i));
endmodule

// File: rtl/frs_resp_pick.sv
// Picks and registers the response to each data request by priority.
// Assumes the flag inputs are registered state from the flag bank.
module frs_resp_pick
    import fault_resp_pkg::*;
#(
    parameter int NAXIS = 2,
    parameter int AXW   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [AXW-1:0]   req_axis_i,
    input  logic             blk_i,
    input  logic             crc_i,
    input  logic             st_i,
    input  logic [NAXIS-1:0] rpt_i,
    output logic             rsp_vld_o,
    output logic [1:0]       rsp_kind_o,
    output logic [1:0]       rsp_stat_o,
    output logic             arm_upd_o
);
    rsp_kind_t  kind_n;
    logic [1:0] stat_n;
    logic       axis_rpt;

    // Select the over-range report of the addressed axis
    always_comb begin
        axis_rpt = 1'b0;
        for (int k = 0; k < NAXIS; k++)
            if (int'(req_axis_i) == k) axis_rpt = rpt_i[k];
    end

    // Priority: init/reset, CRC, self-test, then over-range status
    always_comb begin
        stat_n = ST_NORM;
        if (blk_i || crc_i) kind_n = RSP_INT;
        else if (st_i)      kind_n = RSP_ST;
        else begin
            kind_n = RSP_OK;
            stat_n = axis_rpt ? ST_OVR : ST_NORM;
        end
    end

    // Register the response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld_o  <= 1'b0;
            rsp_kind_o <= RSP_OK;
            rsp_stat_o <= ST_NORM;
            arm_upd_o  <= 1'b0;
        end else begin
            rsp_vld_o  <= req_i;
            rsp_kind_o <= req_i ? kind_n : RSP_OK;
            rsp_stat_o <= req_i ? stat_n : ST_NORM;
            arm_upd_o  <= req_i && (kind_n == RSP_OK);
        end
    end

    // R3
    blk_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && blk_i) |=> (rsp_kind_o == RSP_INT && !arm_upd_o));
    // R10
    st_over_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !blk_i && !crc_i && st_i) |=> (rsp_kind_o == RSP_ST));
    // R12
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_vld_o);
    // R12
    arm_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_upd_o |-> (rsp_vld_o && rsp_kind_o == RSP_OK));
endmodule

// File: rtl/fault_resp_sel.sv
// Top of the fault status and response selector: the device flag bank,
// one over-range tracker per axis, and the response picker.
// Assumes every input is synchronous to clk.
module fault_resp_sel
    import fault_resp_pkg::*;
#(
    parameter int NAXIS = 2,
    localparam int AXW  = (NAXIS > 1) ? $clog2(NAXIS) : 1,
    localparam int STW  = B_OVR0 + NAXIS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done_i,
    input  logic             lock_i,
    input  logic             wcrc_fault_i,
    input  logic             otp_fault_i,
    input  logic             st_fault_i,
    input  logic [NAXIS-1:0] ovr_i,
    input  logic             stat_rd_i,
    input  logic             req_i,
    input  logic [AXW-1:0]   req_axis_i,
    output logic [STW-1:0]   stat_o,
    output logic             rsp_vld_o,
    output logic [1:0]       rsp_kind_o,
    output logic [1:0]       rsp_stat_o,
    output logic             arm_upd_o,
    output logic             pcm_en_o
);
    logic init_busy, rst_seen, wcrc, otp, st_err;
    logic [NAXIS-1:0] ovr_flag, ovr_rpt;

    frs_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .init_done_i(init_done_i), .lock_i(lock_i),
        .wcrc_fault_i(wcrc_fault_i), .otp_fault_i(otp_fault_i),
        .st_fault_i(st_fault_i), .stat_rd_i(stat_rd_i),
        .init_busy_o(init_busy), .rst_seen_o(rst_seen), .wcrc_o(wcrc),
        .otp_o(otp), .st_err_o(st_err)
    );

    for (genvar k = 0; k < NAXIS; k++) begin : g_axis
        logic hit;
        assign hit = req_i && (int'(req_axis_i) == k);
        frs_axis_ovr u_ax (
            .clk(clk), .rst_n(rst_n), .ovr_i(ovr_i[k]), .stat_rd_i(stat_rd_i),
            .req_hit_i(hit), .flag_o(ovr_flag[k]), .rpt_o(ovr_rpt[k])
        );
    end

    frs_resp_pick #(.NAXIS(NAXIS), .AXW(AXW)) u_pick (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_axis_i(req_axis_i),
        .blk_i(init_busy | rst_seen), .crc_i(wcrc | otp), .st_i(st_err),
        .rpt_i(ovr_rpt), .rsp_vld_o(rsp_vld_o), .rsp_kind_o(rsp_kind_o),
        .rsp_stat_o(rsp_stat_o), .arm_upd_o(arm_upd_o)
    );

    // Assemble the status view from the current (pre-clear) flags
    always_comb begin
        stat_o         = '0;
        stat_o[B_INIT] = init_busy;
        stat_o[B_RST]  = rst_seen;
        stat_o[B_IDE]  = wcrc | otp | st_err;
        stat_o[B_WCRC] = wcrc;
        stat_o[B_OTP]  = otp;
        stat_o[B_ST]   = st_err;
        stat_o[STW-1:B_OVR0] = ovr_flag;
    end

    assign pcm_en_o = ~(init_busy | rst_seen);

    // R4
    crc_pcm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[B_OTP] && !stat_o[B_INIT] && !stat_o[B_RST]) |-> pcm_en_o);
endmodule

// File: tb/sim_fault_resp_sel.sv
module sim_fault_resp_sel;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_done_i = 0, lock_i = 0, wcrc_fault_i = 0, otp_fault_i = 0;
    logic st_fault_i = 0, stat_rd_i = 0, req_i = 0;
    logic [1:0] ovr_i = '0;
    logic [0:0] req_axis_i = '0;
    logic [7:0] stat_o;
    logic rsp_vld_o, arm_upd_o, pcm_en_o;
    logic [1:0] rsp_kind_o, rsp_stat_o;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [4:0] sb_q[$];   // {kind, stat, arm}
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_resp_sel u0 (
        .clk(clk), .rst_n(rst_n), .init_done_i(init_done_i), .lock_i(lock_i),
        .wcrc_fault_i(wcrc_fault_i), .otp_fault_i(otp_fault_i),
        .st_fault_i(st_fault_i), .ovr_i(ovr_i), .stat_rd_i(stat_rd_i),
        .req_i(req_i), .req_axis_i(req_axis_i), .stat_o(stat_o),
        .rsp_vld_o(rsp_vld_o), .rsp_kind_o(rsp_kind_o),
        .rsp_stat_o(rsp_stat_o), .arm_upd_o(arm_upd_o), .pcm_en_o(pcm_en_o)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard whenever a response appears
    always @(negedge clk) begin
        if (rst_n && rsp_vld_o) begin
            if (sb_q.size() == 0) chk("R12 unexpected response", 1, 0);
            else begin
                logic [4:0] e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {rsp_kind_o, rsp_stat_o, arm_upd_o}, e);
            end
        end
    end

    // Driver: issue one request and push its expected response
    task automatic req(input int ax, input logic [1:0] k, input logic [1:0] s,
                       input logic arm, input string tag);
        req_axis_i = ax[0:0];
        req_i = 1'b1;
        sb_q.push_back({k, s, arm});
        tag_q.push_back(tag);
        tick();
        req_i = 1'b0;
        tick();
    endtask

    task automatic stat_is(input int exp, input string tag);
        @(negedge clk);
        chk(tag, stat_o, exp);
        tick();
    endtask

    // Status read; checks the view in the read cycle and after it
    task automatic rd(input int pre, input int post, input string tag);
        stat_rd_i = 1'b1;
        @(negedge clk);
        chk({tag, " pre-clear R11"}, stat_o, pre);
        tick();
        stat_rd_i = 1'b0;
        @(negedge clk);
        chk({tag, " after read"}, stat_o, post);
        tick();
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; tick(); sig = 1'b0;
    endtask

    task automatic boot(input string tag);
        rst_n = 1'b0; repeat (3) tick(); rst_n = 1'b1;
        @(negedge clk);
        chk({tag, " R1 status after reset"}, stat_o, 8'h03);
        chk({tag, " R1 pcm off after reset"}, pcm_en_o, 0);
        tick();
    endtask

    initial begin
        boot("boot1");
        req(0, 2'b01, 2'b00, 0, "R3 request during init");
        pulse(init_done_i);
        stat_is(8'h02, "R2 init-busy cleared");
        chk("R2 pcm off while reset-seen", pcm_en_o, 0);
        req(0, 2'b01, 2'b00, 0, "R3 request with reset-seen");
        rd(8'h02, 8'h00, "R2 reset-seen read");
        chk("R2 pcm on", pcm_en_o, 1);
        req(0, 2'b00, 2'b00, 1, "R12 normal valid data");

        ovr_i[1] = 1'b1; tick();
        req(1, 2'b00, 2'b10, 1, "R8 over-range axis1");
        req(0, 2'b00, 2'b00, 1, "R8 other axis normal");
        stat_is(8'h80, "R8 axis1 flag");
        ovr_i[1] = 1'b0; tick();
        req(1, 2'b00, 2'b10, 1, "R9 one extra over-range report");
        req(1, 2'b00, 2'b00, 1, "R9 normal afterwards");
        stat_is(8'h80, "R9 flag held until read");
        rd(8'h80, 8'h00, "R9 flag read");

        st_fault_i = 1'b1; tick();
        req(0, 2'b10, 2'b00, 0, "R7 self-test response");
        rd(8'h24, 8'h24, "R7 read while present");
        st_fault_i = 1'b0; tick();
        stat_is(8'h24, "R7 held after fault gone");
        rd(8'h24, 8'h00, "R7 read after fault gone");
        req(0, 2'b00, 2'b00, 1, "R7 recovered");

        ovr_i[0] = 1'b1; st_fault_i = 1'b1; tick();
        req(0, 2'b10, 2'b00, 0, "R10 self-test over over-range");
        st_fault_i = 1'b0; tick();
        rd(8'h64, 8'h40, "R10 clear self-test");
        req(0, 2'b00, 2'b10, 1, "R8 over-range after self-test");
        ovr_i[0] = 1'b0; tick();
        req(0, 2'b00, 2'b10, 1, "R9 axis0 tail");
        req(0, 2'b00, 2'b00, 1, "R9 axis0 normal");
        rd(8'h40, 8'h00, "R9 axis0 read");

        lock_i = 1'b0; st_fault_i = 1'b1; pulse(wcrc_fault_i);
        stat_is(8'h2C, "R4 writable CRC sets internal error");
        chk("R4 pcm unaffected by CRC", pcm_en_o, 1);
        req(0, 2'b01, 2'b00, 0, "R10 CRC over self-test");
        st_fault_i = 1'b0; tick();
        rd(8'h2C, 8'h00, "R5 unlocked CRC clears");
        req(1, 2'b00, 2'b00, 1, "R5 recovered");

        lock_i = 1'b1; pulse(wcrc_fault_i); lock_i = 1'b0;
        rd(8'h0C, 8'h0C, "R5 locked CRC survives read");
        req(1, 2'b01, 2'b00, 0, "R4 request with locked CRC");

        boot("boot2");
        pulse(init_done_i);
        rd(8'h02, 8'h00, "R2 boot2 read");
        pulse(otp_fault_i);
        rd(8'h14, 8'h14, "R6 OTP survives read");
        chk("R4 pcm on with OTP", pcm_en_o, 1);
        req(0, 2'b01, 2'b00, 0, "R4 OTP response");

        boot("boot3");
        pulse(otp_fault_i);
        stat_is(8'h17, "R10 OTP during init");
        chk("R10 init dominates pcm", pcm_en_o, 0);
        req(0, 2'b01, 2'b00, 0, "R10 init with OTP");
        repeat (3) tick();
        chk("R12 scoreboard drained", sb_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule